// File: doc/BRIEF.md
# Prioritised Maskable Interrupt Controller

This block collects eight level-sensitive interrupt request lines, passes each through a two-flop synchroniser, and gates the synchronised lines with a per-line enable mask. Line 7 has the highest priority and line 0 the lowest. Whenever any enabled line is active, the block raises a request to the processor.

When the processor acknowledges, the block does three things. It stores the number of the winning line, and it saves the mask as it stood just before the acknowledge. It also clears the enable bits of the winning line and of every lower line, so that only strictly higher lines can interrupt the handler. The handler address comes from a programmable base plus the stored number times four, which gives one four-byte entry per line. A return strobe at the end of the handler puts the saved mask back. Software can overwrite the mask at any time through a write port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A change on `irq_in` reaches `irq_req` exactly two rising clock edges after it is applied. After the first edge the old value still shows.
- R2: `irq_req` is 1 exactly when a synchronised line and its bit in `mask_out` are both 1. A mask bit of 1 enables its line, and a mask of zero forces `irq_req` low.
- R3: Among the active enabled lines, the one with the highest index wins the encoding.
- R4: An edge with `ack`=1 and `irq_req`=1 stores the winning index in `irq_num`. On every other edge `irq_num` keeps its value.
- R5: `irq_vec` equals the base register plus `irq_num` shifted left by 2. A `base_wr` edge loads the base register from `base_wdata`.
- R6: An accepted acknowledge of line k clears mask bits k down to 0 and keeps bits above k.
- R7: An accepted acknowledge copies the previous mask into a one-entry save register. An edge with `rti`=1 and no accepted acknowledge loads the mask from that save register.
- R8: An acknowledge while `irq_req` is 0 changes neither `irq_num` nor the mask nor the save register.
- R9: On an edge with `mask_wr`=1, `mask_out` takes `mask_wdata`, even if an accepted acknowledge happens on the same edge. That acknowledge still stores its number and saves the pre-edge mask.
- R10: After reset, `mask_out`=0, `irq_req`=0, `irq_num`=0 and `irq_vec`=0.
- R11: When an accepted acknowledge and `rti` occur on the same edge, the acknowledge's tightening applies and the restore is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Level-sensitive request lines, asynchronous |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 8 | New mask value, 1 enables a line |
| base_wr | input | 1 | Vector base write strobe |
| base_wdata | input | 16 | New vector base |
| ack | input | 1 | Processor acknowledge |
| rti | input | 1 | Return strobe, restores the saved mask |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_num | output | 3 | Stored number of the acknowledged line |
| irq_vec | output | 16 | Handler address |
| mask_out | output | 8 | Current mask |

## Verification
Three events can compete for the mask on the same edge: an acknowledge that tightens it, a software write, and a return that restores it. The bench sets up an acknowledge together with a mask write, and an acknowledge together with a return, using known pending lines. It then checks the mask that wins, the stored number, and the saved value that a later return brings back. Random phases drive all strobes independently, so these collisions also occur by chance. They are compared against a cycle model in the bench that applies the same precedence: write over tighten over restore.

// File: rtl/irq_pkg.sv
package irq_pkg;
   // Which source updates the mask on a given edge
   typedef enum logic [1:0] {
      MSK_HOLD    = 2'd0,
      MSK_WRITE   = 2'd1,
      MSK_TIGHTEN = 2'd2,
      MSK_RESTORE = 2'd3
   } mask_src_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad
      $error("irq_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage[s] <= '0;
         end else begin
            if (s == 0) stage[s] <= d;
            else        stage[s] <= stage[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q = stage[STAGES-1];
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int NUM_SRC = 8,
   parameter int ID_W    = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0] pend,
   output logic               any,
   output logic [ID_W-1:0]    id
);
   // Higher index overrides lower, so the top active line wins
   always_comb begin
      id = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (pend[i]) id = ID_W'(i);
      end
   end

   assign any = |pend;
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
   import irq_pkg::*;
#(
   parameter int NUM_SRC = 8,
   parameter int ID_W    = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [NUM_SRC-1:0] wdata,
   input  logic               take,
   input  logic [ID_W-1:0]    take_id,
   input  logic               restore,
   output logic [NUM_SRC-1:0] mask_q
);
   logic [NUM_SRC-1:0] save_q;
   logic [NUM_SRC-1:0] tight;
   mask_src_e          src;

   // Keep only the lines strictly above the accepted one
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_tight
      assign tight[i] = mask_q[i] & (take_id < ID_W'(i));
   end

   always_comb begin
      if (wr)           src = MSK_WRITE;
      else if (take)    src = MSK_TIGHTEN;
      else if (restore) src = MSK_RESTORE;
      else              src = MSK_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         save_q <= '0;
      end else begin
         if (take) save_q <= mask_q;
         unique case (src)
            MSK_WRITE:   mask_q <= wdata;
            MSK_TIGHTEN: mask_q <= tight;
            MSK_RESTORE: mask_q <= save_q;
            default:     mask_q <= mask_q;
         endcase
      end
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
   parameter int NUM_SRC     = 8,
   parameter int ADDR_W      = 16,
   parameter int ENTRY_SHIFT = 2,
   parameter int SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] RST_BASE = '0,
   localparam int ID_W = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_in,
   input  logic               mask_wr,
   input  logic [NUM_SRC-1:0] mask_wdata,
   input  logic               base_wr,
   input  logic [ADDR_W-1:0]  base_wdata,
   input  logic               ack,
   input  logic               rti,
   output logic               irq_req,
   output logic [ID_W-1:0]    irq_num,
   output logic [ADDR_W-1:0]  irq_vec,
   output logic [NUM_SRC-1:0] mask_out
);
   if (NUM_SRC < 2 || (1 << ID_W) != NUM_SRC) begin : g_bad_num
      $error("prio_irq_ctrl: NUM_SRC must be a power of two >= 2");
   end
   if (ID_W + ENTRY_SHIFT > ADDR_W) begin : g_bad_addr
      $error("prio_irq_ctrl: vector table does not fit ADDR_W");
   end

   logic [NUM_SRC-1:0] sync_q;
   logic [NUM_SRC-1:0] pend;
   logic               any;
   logic [ID_W-1:0]    win_id;
   logic               take;
   logic [ID_W-1:0]    num_q;
   logic [ADDR_W-1:0]  base_q;

   irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(irq_in), .q(sync_q)
   );

   assign pend = sync_q & mask_out;

   irq_prio_enc #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_enc (
      .pend(pend), .any(any), .id(win_id)
   );

   assign take = ack & any;

   irq_mask_ctrl #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_mask (
      .clk(clk), .rst_n(rst_n), .wr(mask_wr), .wdata(mask_wdata),
      .take(take), .take_id(win_id), .restore(rti), .mask_q(mask_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         num_q  <= '0;
         base_q <= RST_BASE;
      end else begin
         if (take)    num_q  <= win_id;
         if (base_wr) base_q <= base_wdata;
      end
   end

   assign irq_req = any;
   assign irq_num = num_q;
   assign irq_vec = base_q + (ADDR_W'(num_q) << ENTRY_SHIFT);
endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker #(
   parameter int NUM_SRC = 8,
   parameter int ID_W    = $clog2(NUM_SRC)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ack,
   input logic               rti,
   input logic               mask_wr,
   input logic [NUM_SRC-1:0] mask_wdata,
   input logic               irq_req,
   input logic [ID_W-1:0]    irq_num,
   input logic [NUM_SRC-1:0] mask_out
);
   a_r2_zero_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_out == '0) |-> !irq_req);

   a_r4_num_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(ack && irq_req) |=> $stable(irq_num));

   a_r6_taken_line_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && irq_req && !mask_wr) |=> (mask_out[irq_num] == 1'b0));

   a_r8_idle_ack_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !irq_req && !mask_wr && !rti) |=> $stable(mask_out));

   a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr |=> (mask_out == $past(mask_wdata)));
endmodule

bind prio_irq_ctrl irq_ctrl_checker #(.NUM_SRC(NUM_SRC)) u_irq_chk (
   .clk(clk), .rst_n(rst_n), .ack(ack), .rti(rti), .mask_wr(mask_wr),
   .mask_wdata(mask_wdata), .irq_req(irq_req), .irq_num(irq_num),
   .mask_out(mask_out)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
   logic        clk = 0;
   logic        rst_n = 0;
   logic [7:0]  irq_in = 0;
   logic        mask_wr = 0, base_wr = 0, ack = 0, rti = 0;
   logic [7:0]  mask_wdata = 0;
   logic [15:0] base_wdata = 0;
   logic        irq_req;
   logic [2:0]  irq_num;
   logic [15:0] irq_vec;
   logic [7:0]  mask_out;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // bench model
   logic [7:0]  m_s1 = 0, m_s2 = 0, m_mask = 0, m_save = 0;
   logic [2:0]  m_num = 0;
   logic [15:0] m_base = 0;

   always #2.5 clk = ~clk;

   prio_irq_ctrl i_prio_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask_wr(mask_wr),
      .mask_wdata(mask_wdata), .base_wr(base_wr), .base_wdata(base_wdata),
      .ack(ack), .rti(rti), .irq_req(irq_req), .irq_num(irq_num),
      .irq_vec(irq_vec), .mask_out(mask_out)
   );

   function automatic logic [2:0] f_enc(input logic [7:0] p);
      logic [2:0] r = 0;
      for (int i = 0; i < 8; i++) if (p[i]) r = 3'(i);
      return r;
   endfunction

   function automatic logic [7:0] f_keep_above(input logic [7:0] m, input logic [2:0] k);
      logic [7:0] r = 0;
      for (int i = 0; i < 8; i++) if (i > int'(k)) r[i] = m[i];
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cmp_all();
      chk(irq_req == |(m_s2 & m_mask), "R2 irq_req", int'(irq_req), int'(|(m_s2 & m_mask)));
      chk(irq_num == m_num, "R4 irq_num", int'(irq_num), int'(m_num));
      chk(irq_vec == m_base + {11'd0, m_num, 2'b00}, "R5 irq_vec", int'(irq_vec),
          int'(m_base + {11'd0, m_num, 2'b00}));
      chk(mask_out == m_mask, "R6 mask_out", int'(mask_out), int'(m_mask));
   endtask

   // one clock: drive at negedge, model the edge, compare at next negedge
   task automatic cyc(input logic a, input logic r, input logic mw, input logic [7:0] md,
                      input logic bw, input logic [15:0] bd);
      logic [7:0] pend;
      logic       acc;
      logic [7:0] old_save;
      ack = a; rti = r; mask_wr = mw; mask_wdata = md; base_wr = bw; base_wdata = bd;
      @(posedge clk);
      pend = m_s2 & m_mask;
      acc = a && (pend != 0);
      old_save = m_save;
      if (acc) begin
         m_num = f_enc(pend);
         m_save = m_mask;
      end
      if (mw)       m_mask = md;
      else if (acc) m_mask = f_keep_above(m_mask, f_enc(pend));
      else if (r)   m_mask = old_save;
      if (bw) m_base = bd;
      m_s2 = m_s1;
      m_s1 = irq_in;
      @(negedge clk);
      ack = 0; rti = 0; mask_wr = 0; base_wr = 0;
      cmp_all();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 8'h00, 0, 16'h0);
   endtask

   initial begin
      #200000;
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      @(negedge clk); @(negedge clk);
      // R10 reset state
      chk(mask_out == 0, "R10 mask", int'(mask_out), 0);
      chk(irq_req == 0, "R10 req", int'(irq_req), 0);
      chk(irq_num == 0, "R10 num", int'(irq_num), 0);
      chk(irq_vec == 0, "R10 vec", int'(irq_vec), 0);
      rst_n = 1;
      @(negedge clk);

      cyc(0, 0, 1, 8'hFF, 1, 16'h1000);
      // R1: two-edge synchroniser latency
      irq_in = 8'h10;
      cyc(0, 0, 0, 8'h00, 0, 16'h0);
      chk(irq_req == 0, "R1 after one edge", int'(irq_req), 0);
      cyc(0, 0, 0, 8'h00, 0, 16'h0);
      chk(irq_req == 1, "R1 after two edges", int'(irq_req), 1);

      // R3: highest index wins, R5 vector
      irq_in = 8'h91; idle(2);
      cyc(1, 0, 0, 8'h00, 0, 16'h0);
      chk(irq_num == 3'd7, "R3 top line", int'(irq_num), 7);
      chk(irq_vec == 16'h101C, "R5 vec line7", int'(irq_vec), 'h101C);
      chk(mask_out == 8'h00, "R6 mask after line7", int'(mask_out), 0);
      cyc(0, 1, 0, 8'h00, 0, 16'h0);
      chk(mask_out == 8'hFF, "R7 restore", int'(mask_out), 'hFF);

      // R6 partial tighten, R8 idle ack
      irq_in = 8'h15; idle(2);
      cyc(1, 0, 0, 8'h00, 0, 16'h0);
      chk(irq_num == 3'd4, "R3 line4", int'(irq_num), 4);
      chk(mask_out == 8'hE0, "R6 keep above 4", int'(mask_out), 'hE0);
      chk(irq_req == 0, "R6 req dropped", int'(irq_req), 0);
      cyc(1, 0, 0, 8'h00, 0, 16'h0);
      chk(irq_num == 3'd4 && mask_out == 8'hE0, "R8 idle ack", int'(mask_out), 'hE0);
      cyc(0, 1, 0, 8'h00, 0, 16'h0);
      chk(mask_out == 8'hFF, "R7 save untouched by idle ack", int'(mask_out), 'hFF);

      // R9 write with ack on same edge
      cyc(1, 0, 1, 8'h0F, 0, 16'h0);
      chk(mask_out == 8'h0F, "R9 write wins", int'(mask_out), 'h0F);
      chk(irq_num == 3'd4, "R9 number stored", int'(irq_num), 4);
      cyc(0, 1, 0, 8'h00, 0, 16'h0);
      chk(mask_out == 8'hFF, "R9 saved pre-edge mask", int'(mask_out), 'hFF);

      // R11 ack with rti on same edge
      cyc(1, 1, 0, 8'h00, 0, 16'h0);
      chk(mask_out == 8'hE0, "R11 rti dropped", int'(mask_out), 'hE0);
      cyc(0, 1, 0, 8'h00, 0, 16'h0);

      // random phase
      for (int it = 0; it < 1500; it++) begin
         logic [31:0] r;
         r = $urandom;
         if (r[3:0] == 0) irq_in = 8'($urandom);
         cyc(r[4] & r[5], r[6] & r[7] & r[8], r[9] & r[10] & r[11], 8'($urandom),
             r[12] & r[13] & r[14] & r[15], 16'($urandom));
      end

      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule